// File: doc/BRIEF.md
# Six-Channel Cascadable Interval Timer

This block is a bank of up-counting 16-bit timer channels behind a byte-wide register bus. A shared divider chain produces count enables at 1, 1/4, 1/16 and 1/64 of the peripheral clock. Each channel picks one of these enables, or a chained mode in which it counts the wrap-arounds of a fixed neighbour. Two compare registers per channel raise sticky match flags, and either one can be chosen to reset the count. Channels are arranged in groups of three. Inside each group, the wrap of the third channel can drive the second, which forms a 32-bit counter.

Software writes a run mask, a per-channel mode byte, the count bytes and the compare bytes. It then polls the status byte. Reads are combinational from the address, so data is valid in the same cycle. Writes take effect at the next clock edge.

Every channel is in one of six clock modes, named by an enumeration: CK_DIV1, CK_DIV4, CK_DIV16, CK_DIV64, CK_CHAIN and CK_IDLE. Every channel is also in one of three clear modes: CLR_NONE, CLR_ON_A and CLR_ON_B. A mode changes only when the mode byte is written. No transitions happen on their own.

Top module: `cascade_timer_unit`

## Requirements
- R1: Each channel counter goes up by one per enabled count event. It wraps from 0xFFFF to 0x0000, and that wrap sets status bit 4.
- R2: Mode byte bits [3:0] select the count enable. Codes 0, 1, 2 and 3 divide the clock by 1, 4, 16 and 64. Over any window of K×N clock edges, a divide-by-N channel advances exactly K.
- R3: The run register is at address 0x00. Bit n enables channel n. While bit n is 0, channel n's counter holds its value.
- R4: Code 0xF makes channel 1 count once per wrap of channel 2, and channel 4 count once per wrap of channel 5, in the same edge. Codes 4 to 14 never count.
- R5: No other wrap is forwarded. A channel at position 0 or 2 of its group with code 0xF never counts.
- R6: Mode byte bits [7:5] pick the clear source. 001 clears the counter to 0 when the incremented value equals compare A, and 010 does the same for compare B. Every other value never clears.
- R7: Status bit 0 is set when an increment produces the value of compare A, and status bit 1 when it produces the value of compare B. Both bits are set whatever the clear source is.
- R8: Status bits are sticky. Writing 0 to a bit clears it, and writing 1 leaves it unchanged. A hardware set in the same edge as a clearing write wins.
- R9: A write to a counter byte replaces that byte and cancels that edge's increment. The counter and compare bytes can be written and read back at any time.
- R10: After reset, all registers read 0, except compare A and compare B, which read 0xFFFF.
- R11: Channel n sits at address (n+1)×0x10. Its registers are mode at +0, status at +5, counter low/high at +6/+7, compare A low/high at +8/+9 and compare B low/high at +10/+11. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data for bus_addr, valid in the same cycle |

## Verification
The bench builds the unit with its default of six channels, which gives two complete groups of three. Both chained pairs can then be exercised side by side, and the bench can also show that the non-chained positions ignore code 0xF. With the 16-bit counter width, a wrap is reached in a few edges by preloading the counter near 0xFFFF. With the divider depth of four taps, each ratio is measured over an exact multiple of its period.

// File: rtl/ctu_pkg.sv
package ctu_pkg;

    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 16;
    localparam int NUM_DIV = 4;
    localparam int GRP     = 3;
    localparam int CHAIN_DST = 1;
    localparam int CHAIN_SRC = 2;

    localparam logic [3:0] SEL_CHAIN = 4'hF;

    localparam logic [3:0] OFS_MODE  = 4'd0;
    localparam logic [3:0] OFS_STAT  = 4'd5;
    localparam logic [3:0] OFS_CNT_L = 4'd6;
    localparam logic [3:0] OFS_CNT_H = 4'd7;
    localparam logic [3:0] OFS_CA_L  = 4'd8;
    localparam logic [3:0] OFS_CA_H  = 4'd9;
    localparam logic [3:0] OFS_CB_L  = 4'd10;
    localparam logic [3:0] OFS_CB_H  = 4'd11;

    localparam int FLG_A   = 0;
    localparam int FLG_B   = 1;
    localparam int FLG_OVF = 4;

    typedef enum logic [2:0] {
        CK_DIV1, CK_DIV4, CK_DIV16, CK_DIV64, CK_CHAIN, CK_IDLE
    } clk_mode_e;

    typedef enum logic [1:0] {
        CLR_NONE, CLR_ON_A, CLR_ON_B
    } clr_src_e;

    function automatic clk_mode_e decode_clk(input logic [3:0] sel);
        clk_mode_e m;
        unique case (sel)
            4'd0:      m = CK_DIV1;
            4'd1:      m = CK_DIV4;
            4'd2:      m = CK_DIV16;
            4'd3:      m = CK_DIV64;
            SEL_CHAIN: m = CK_CHAIN;
            default:   m = CK_IDLE;
        endcase
        return m;
    endfunction

    function automatic clr_src_e decode_clr(input logic [2:0] code);
        clr_src_e c;
        unique case (code)
            3'b001:  c = CLR_ON_A;
            3'b010:  c = CLR_ON_B;
            default: c = CLR_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ctu_prescaler.sv
module ctu_prescaler
    import ctu_pkg::*;
#(
    parameter int TAPS = NUM_DIV
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TAPS-1:0] tick
);
    localparam int DW = (TAPS > 1) ? 2 * (TAPS - 1) : 1;

    logic [DW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == 0) begin : g_full
            assign tick[k] = 1'b1;
        end else begin : g_div
            assign tick[k] = &div_q[2*k-1:0];

            // R2
            pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick[k] |=> !tick[k]);

            if (k > 1) begin : g_nest
                // R2
                pre_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    tick[k] |-> tick[k-1]);
            end
        end
    end

endmodule

// File: rtl/ctu_route.sv
module ctu_route
    import ctu_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic [NCH-1:0]        run,
    input  logic [NCH-1:0][3:0]   sel,
    input  logic [NUM_DIV-1:0]    tick,
    input  logic [NCH-1:0]        at_max,
    input  logic [NCH-1:0]        cnt_wr,
    output logic [NCH-1:0]        step,
    output logic [NCH-1:0]        wrap
);

    always_comb begin : p_route
        logic src;
        step = '0;
        wrap = '0;
        for (int n = NCH - 1; n >= 0; n--) begin
            src = 1'b0;
            unique case (decode_clk(sel[n]))
                CK_DIV1:  src = tick[0];
                CK_DIV4:  src = tick[1];
                CK_DIV16: src = tick[2];
                CK_DIV64: src = tick[3];
                CK_CHAIN: src = ((n % GRP) == CHAIN_DST) && (n + 1 < NCH)
                                && wrap[(n + 1 < NCH) ? n + 1 : n];
                default:  src = 1'b0;
            endcase
            step[n] = run[n] && src && !cnt_wr[n];
            wrap[n] = step[n] && at_max[n];
        end
    end

endmodule

// File: rtl/ctu_channel.sv
module ctu_channel
    import ctu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        ofs,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              step,
    output logic [BYTE_W-1:0] mode_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              at_max,
    output logic              cnt_wr,
    output logic [BYTE_W-1:0] rd_byte
);
    logic [CNT_W-1:0] cmp_a_q, cmp_b_q, cnt_inc, cnt_d;
    logic             flg_a_q, flg_b_q, flg_o_q;
    logic             hit_a, hit_b, wrap_evt, do_clr;
    logic             stat_wr;
    clr_src_e         clr_mode;

    assign cnt_inc  = cnt_q + 1'b1;
    assign at_max   = &cnt_q;
    assign cnt_wr   = wr_en && (ofs == OFS_CNT_L || ofs == OFS_CNT_H);
    assign stat_wr  = wr_en && (ofs == OFS_STAT);
    assign clr_mode = decode_clr(mode_q[7:5]);
    assign hit_a    = step && (cnt_inc == cmp_a_q);
    assign hit_b    = step && (cnt_inc == cmp_b_q);
    assign wrap_evt = step && at_max;

    always_comb begin
        unique case (clr_mode)
            CLR_ON_A: do_clr = hit_a;
            CLR_ON_B: do_clr = hit_b;
            default:  do_clr = 1'b0;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        if (wr_en && ofs == OFS_CNT_L)      cnt_d = {cnt_q[15:8], wr_data};
        else if (wr_en && ofs == OFS_CNT_H) cnt_d = {wr_data, cnt_q[7:0]};
        else if (do_clr)                    cnt_d = '0;
        else if (step)                      cnt_d = cnt_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            cnt_q   <= '0;
            cmp_a_q <= '1;
            cmp_b_q <= '1;
            flg_a_q <= 1'b0;
            flg_b_q <= 1'b0;
            flg_o_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (wr_en) begin
                unique case (ofs)
                    OFS_MODE: mode_q        <= wr_data;
                    OFS_CA_L: cmp_a_q[7:0]  <= wr_data;
                    OFS_CA_H: cmp_a_q[15:8] <= wr_data;
                    OFS_CB_L: cmp_b_q[7:0]  <= wr_data;
                    OFS_CB_H: cmp_b_q[15:8] <= wr_data;
                    default: ;
                endcase
            end
            flg_a_q <= (stat_wr ? (flg_a_q & wr_data[FLG_A])   : flg_a_q) | hit_a;
            flg_b_q <= (stat_wr ? (flg_b_q & wr_data[FLG_B])   : flg_b_q) | hit_b;
            flg_o_q <= (stat_wr ? (flg_o_q & wr_data[FLG_OVF]) : flg_o_q) | wrap_evt;
        end
    end

    always_comb begin
        rd_byte = '0;
        unique case (ofs)
            OFS_MODE:  rd_byte = mode_q;
            OFS_STAT:  begin
                rd_byte[FLG_A]   = flg_a_q;
                rd_byte[FLG_B]   = flg_b_q;
                rd_byte[FLG_OVF] = flg_o_q;
            end
            OFS_CNT_L: rd_byte = cnt_q[7:0];
            OFS_CNT_H: rd_byte = cnt_q[15:8];
            OFS_CA_L:  rd_byte = cmp_a_q[7:0];
            OFS_CA_H:  rd_byte = cmp_a_q[15:8];
            OFS_CB_L:  rd_byte = cmp_b_q[7:0];
            OFS_CB_H:  rd_byte = cmp_b_q[15:8];
            default:   rd_byte = '0;
        endcase
    end

    // R1
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> flg_o_q);

    // R1
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> cnt_q == '0);

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_clr |=> cnt_q == '0);

    // R8
    hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> flg_a_q);

    // R9
    wr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == OFS_CNT_L) |=> cnt_q[7:0] == $past(wr_data));

endmodule

// File: rtl/cascade_timer_unit.sv
module cascade_timer_unit
    import ctu_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    localparam int WIN_W = ADDR_W - 4;

    logic [WIN_W-1:0]           win;
    logic [3:0]                 ofs;
    logic [NCH-1:0]             run_q;
    logic [NUM_DIV-1:0]         tick;
    logic [NCH-1:0][3:0]        sel;
    logic [NCH-1:0][7:0]        mode_all;
    logic [NCH-1:0][CNT_W-1:0]  cnt_all;
    logic [NCH-1:0][7:0]        rd_all;
    logic [NCH-1:0]             at_max, cnt_wr, step, wrap, ch_we;

    assign win = bus_addr[ADDR_W-1:4];
    assign ofs = bus_addr[3:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    run_q <= '0;
        else if (bus_we && win == '0 && ofs == 4'd0)   run_q <= bus_wdata[NCH-1:0];
    end

    ctu_prescaler #(.TAPS(NUM_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    ctu_route #(.NCH(NCH)) u_route (
        .run   (run_q),
        .sel   (sel),
        .tick  (tick),
        .at_max(at_max),
        .cnt_wr(cnt_wr),
        .step  (step),
        .wrap  (wrap)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign ch_we[n] = bus_we && (win == WIN_W'(n + 1));
        assign sel[n]   = mode_all[n][3:0];

        ctu_channel u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (ch_we[n]),
            .ofs    (ofs),
            .wr_data(bus_wdata),
            .step   (step[n]),
            .mode_q (mode_all[n]),
            .cnt_q  (cnt_all[n]),
            .at_max (at_max[n]),
            .cnt_wr (cnt_wr[n]),
            .rd_byte(rd_all[n])
        );

        // R3
        halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[n] && !cnt_wr[n]) |=> $stable(cnt_all[n]));

        if ((n % GRP) != CHAIN_DST) begin : g_nochain
            // R5
            no_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sel[n] == SEL_CHAIN && !cnt_wr[n]) |=> $stable(cnt_all[n]));
        end else if (n + 1 < NCH) begin : g_chain
            // R4
            chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wrap[n+1] && run_q[n] && sel[n] == SEL_CHAIN && !cnt_wr[n]
                 && mode_all[n][7:5] == 3'b000)
                |=> cnt_all[n] == $past(cnt_all[n]) + 1'b1);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (win == '0 && ofs == 4'd0) bus_rdata = 8'(run_q);
        for (int n = 0; n < NCH; n++) begin
            if (win == WIN_W'(n + 1)) bus_rdata = rd_all[n];
        end
    end

endmodule

// File: tb/cascade_timer_unit_tb.sv
module cascade_timer_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cascade_timer_unit u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic int base(input int ch);
        return (ch + 1) * 16;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        bus_addr  = 8'(a);
        bus_wdata = 8'(d);
        bus_we    = 1'b1;
        @(posedge clk);
        #1;
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        bus_addr = 8'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic rd16(input int a, output int d);
        int lo, hi;
        rd(a, lo);
        rd(a + 1, hi);
        d = (hi << 8) | lo;
    endtask

    task automatic wr16(input int a, input int d);
        wr(a, d & 8'hFF);
        wr(a + 1, (d >> 8) & 8'hFF);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_edges(input int mask, input int m);
        wr(0, mask);
        repeat (m - 1) @(posedge clk);
        #1;
        wr(0, 0);
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        rd(0, v);               chk("R10 run reg", v, 0);
        rd(base(0) + 0, v);     chk("R10 mode", v, 0);
        rd16(base(2) + 6, v);   chk("R10 counter", v, 0);
        rd16(base(3) + 8, v);   chk("R10 compare A", v, 16'hFFFF);
        rd16(base(5) + 10, v);  chk("R10 compare B", v, 16'hFFFF);
        rd(base(4) + 5, v);     chk("R10 status", v, 0);
    endtask

    task automatic t_map();
        int v;
        do_reset();
        wr16(base(5) + 10, 16'h1234);
        rd16(base(5) + 10, v);  chk("R9 compare B readback", v, 16'h1234);
        wr16(base(1) + 6, 16'hBEEF);
        rd16(base(1) + 6, v);   chk("R9 counter readback", v, 16'hBEEF);
        wr(base(2) + 0, 8'hA5);
        rd(base(2) + 0, v);     chk("R11 mode readback", v, 8'hA5);
        rd(8'h0C, v);           chk("R11 unmapped 0x0C", v, 0);
        rd(base(0) + 15, v);    chk("R11 unmapped ch0+15", v, 0);
        rd(8'h75, v);           chk("R11 unmapped 0x75", v, 0);
    endtask

    task automatic t_prescale();
        int v;
        int codes[5] = '{0, 1, 2, 3, 6};
        int edges[5] = '{20, 64, 128, 256, 32};
        int expv[5]  = '{20, 16, 8, 4, 0};
        do_reset();
        for (int i = 0; i < 5; i++) begin
            wr16(base(0) + 6, 0);
            wr(base(0) + 0, codes[i]);
            run_edges(1, edges[i]);
            rd16(base(0) + 6, v);
            if (i < 4) chk("R2 divide ratio", v, expv[i]);
            else       chk("R4 idle code", v, expv[i]);
        end
        // R3: stopped counter holds
        wr(base(0) + 0, 0);
        wr16(base(0) + 6, 16'h0077);
        repeat (20) @(posedge clk);
        #1;
        rd16(base(0) + 6, v);   chk("R3 halted hold", v, 16'h0077);
    endtask

    task automatic t_chain();
        int v;
        do_reset();
        for (int g = 0; g < 2; g++) begin
            wr(base(3*g) + 0, 8'h0F);
            wr(base(3*g + 1) + 0, 8'h0F);
            wr(base(3*g + 2) + 0, 8'h00);
            wr16(base(3*g + 2) + 6, 16'hFFFE);
        end
        run_edges(8'h3F, 3);
        rd16(base(1) + 6, v);   chk("R4 chain ch1", v, 1);
        rd16(base(2) + 6, v);   chk("R1 source ch2 wrapped", v, 1);
        rd16(base(4) + 6, v);   chk("R4 chain ch4", v, 1);
        rd16(base(5) + 6, v);   chk("R1 source ch5 wrapped", v, 1);
        rd16(base(0) + 6, v);   chk("R5 ch0 not chained", v, 0);
        rd16(base(3) + 6, v);   chk("R5 ch3 not chained", v, 0);
        rd(base(2) + 5, v);     chk("R1 wrap flag ch2", v & 8'h10, 8'h10);
    endtask

    task automatic t_clear();
        int v;
        do_reset();
        // clear on A, B watched only
        wr(base(0) + 0, 8'h20);
        wr16(base(0) + 8, 5);
        wr16(base(0) + 10, 3);
        // clear on B
        wr(base(3) + 0, 8'h40);
        wr16(base(3) + 8, 16'h0100);
        wr16(base(3) + 10, 4);
        // code 011: no clearing
        wr(base(4) + 0, 8'h60);
        wr16(base(4) + 8, 2);
        run_edges(8'h19, 8);
        rd16(base(0) + 6, v);   chk("R6 clear on A", v, 3);
        rd(base(0) + 5, v);     chk("R7 flags A and B", v, 8'h03);
        rd16(base(3) + 6, v);   chk("R6 clear on B", v, 0);
        rd(base(3) + 5, v);     chk("R7 flag B only", v, 8'h02);
        rd16(base(4) + 6, v);   chk("R6 other code no clear", v, 8);
        rd(base(4) + 5, v);     chk("R7 flag A without clear", v, 8'h01);
    endtask

    task automatic t_wrap_status();
        int v;
        do_reset();
        wr16(base(1) + 6, 16'hFFFD);
        run_edges(8'h02, 5);
        rd16(base(1) + 6, v);   chk("R1 wrap count", v, 2);
        rd(base(1) + 5, v);     chk("R7 R1 status after wrap", v, 8'h13);
        wr(base(1) + 5, 8'hEF);
        rd(base(1) + 5, v);     chk("R8 write 0 clears", v, 8'h03);
        wr(base(1) + 5, 8'hFF);
        rd(base(1) + 5, v);     chk("R8 write 1 keeps", v, 8'h03);
        // hardware set in the same edge as a clearing write
        wr16(base(1) + 8, 7);
        wr16(base(1) + 6, 16'hFFFF);
        wr(0, 8'h02);
        wr(base(1) + 5, 8'h00);
        wr(0, 8'h00);
        rd(base(1) + 5, v);     chk("R8 hardware set wins", v, 8'h10);
        rd16(base(1) + 6, v);   chk("R1 count after wrap", v, 1);
    endtask

    task automatic t_override();
        int v;
        do_reset();
        wr16(base(2) + 6, 0);
        wr(0, 8'h04);
        repeat (2) @(posedge clk);
        #1;
        wr(base(2) + 6, 8'h40);
        wr(0, 8'h00);
        rd16(base(2) + 6, v);   chk("R9 write overrides step", v, 16'h0041);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_map();
        t_prescale();
        t_chain();
        t_clear();
        t_wrap_status();
        t_override();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule